// File: doc/BRIEF.md
# Privilege Check and Trap Entry Unit

This block keeps the single user/kernel privilege bit of a processor and decides each cycle whether the instruction on offer may retire or whether control must be redirected to a kernel handler. It takes the decoded instruction class, a small set of interrupt request lines, fault flags raised by other units for the current instruction, and the current program counter. When an entry happens it reports a one-cycle taken pulse, a 4-bit cause code and the handler address. It also keeps the return address and the mode that was active before the entry.

The same path handles both kinds of entry. Synchronous events come from the current instruction: an illegal privileged operation, a system call, a divide fault, a memory protection fault or a bus error. Asynchronous events come from the interrupt lines, which are taken only once the current instruction has completed. Every entry switches to kernel mode and masks interrupts. A return-from-trap instruction issued in kernel mode restores the saved mode, unmasks interrupts and tells the fetch unit to load the saved address. Handler address = vector base + cause × 4.

Top module: `priv_trap_top`

## Requirements
- R1: After reset the unit is in kernel mode with interrupts masked, the saved return address reads 0, and no trap is reported.
- R2: The instruction class codes 2 (return-from-trap), 3 (set mode), 4 (device I/O), 5 (halt), 6 (MMU register write) and 7 (interrupt enable) are privileged. A valid privileged instruction in user mode does not retire and raises cause 2 (illegal instruction), saving its own PC.
- R3: In kernel mode a privileged instruction with no fault retires without a trap. Set-mode (3) loads the mode bit from `modeWrVal` (1 = kernel, 0 = user) at the next edge, and interrupt-enable (7) unmasks interrupts. Class 0 retires in either mode.
- R4: The system-call class (1) is allowed in both modes and raises cause 1, saving the PC of the following instruction (PC + 4).
- R5: Fault flags of a valid instruction raise cause 5 (bus), 4 (memory protection) or 3 (divide), saving the instruction's own PC. The priority is illegal > bus > memory > divide > system call. Fault flags and class have no effect while `instValid` is low.
- R6: Every entry sets kernel mode and masks interrupts at the next edge and records the mode that was current once the instruction had its effect. The vector equals the vector base plus four times the cause. The vector and cause read 0 when no entry is taken.
- R7: Interrupt line i raises cause 8 + i. The lowest-numbered pending line wins. Lines are ignored while interrupts are masked, and any synchronous trap of the same cycle takes precedence.
- R8: An interrupt taken alongside a retiring instruction saves PC + 4. An interrupt taken in a cycle without a valid instruction saves PC. No interrupt is taken in the cycle in which a return-from-trap retires.
- R9: A return-from-trap retiring in kernel mode pulses `retTaken`, restores the saved mode and unmasks interrupts at the next edge; `epcOut` gives the address to resume at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| instValid | input | 1 | An instruction is offered this cycle |
| instClass | input | 3 | Decoded instruction class code |
| modeWrVal | input | 1 | Mode value written by the set-mode class |
| irqReq | input | N_IRQ | Interrupt request lines, line 0 highest priority |
| faultDiv | input | 1 | Divide-by-zero flag for the current instruction |
| faultMem | input | 1 | Memory protection fault flag for the current instruction |
| faultBus | input | 1 | Bus error flag for the current instruction |
| curPc | input | PC_W | PC of the offered instruction, or next fetch address when none |
| retire | output | 1 | The offered instruction completes |
| trapTaken | output | 1 | An entry is taken this cycle |
| trapCause | output | 4 | Cause code of the entry, 0 otherwise |
| trapVector | output | PC_W | Handler address, 0 otherwise |
| epcOut | output | PC_W | Saved return address |
| retTaken | output | 1 | Return-from-trap retires; load `epcOut` into the PC |
| kernelMode | output | 1 | Current mode, 1 = kernel |

## Verification
A corrupted mode bit shows in the cycle after it goes wrong: `kernelMode` reads back directly, and the next privileged instruction either traps or retires against expectation. A wrong mask bit shows as soon as an interrupt line is raised with a retiring instruction. A wrong saved mode shows only after a later return-from-trap, through `kernelMode` one cycle after `retTaken`. The bench sweeps every class under both modes, both mask states, all fault combinations and every interrupt pattern, with a running model that predicts each port value from the requirements.

// File: rtl/privtrap_pkg.sv
`timescale 1ns/1ps
package privtrap_pkg;

  typedef enum logic [2:0] {
    IC_PLAIN   = 3'd0,
    IC_SYSCALL = 3'd1,
    IC_RETURN  = 3'd2,
    IC_SETMODE = 3'd3,
    IC_DEVIO   = 3'd4,
    IC_HALT    = 3'd5,
    IC_MMUWR   = 3'd6,
    IC_IRQON   = 3'd7
  } instClass_e;

  localparam logic [3:0] CAUSE_NONE     = 4'd0;
  localparam logic [3:0] CAUSE_SYSCALL  = 4'd1;
  localparam logic [3:0] CAUSE_ILLEGAL  = 4'd2;
  localparam logic [3:0] CAUSE_DIVZERO  = 4'd3;
  localparam logic [3:0] CAUSE_MEMPROT  = 4'd4;
  localparam logic [3:0] CAUSE_BUSERR   = 4'd5;
  localparam logic [3:0] CAUSE_IRQ_BASE = 4'd8;

  // strobes from the decision logic to the state datapath
  typedef struct packed {
    logic       take;      // entry this cycle
    logic [3:0] cause;     // cause code of the entry
    logic       saveNext;  // save PC + 4 instead of PC
    logic       doReturn;  // return-from-trap retires
    logic       setMode;   // set-mode retires
    logic       irqOn;     // interrupt-enable retires
  } ctrlStrobe_t;

endpackage

// File: rtl/priv_ctrl.sv
`timescale 1ns/1ps
module priv_ctrl
  import privtrap_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instValid,
  input  logic [2:0]        instClass,
  input  logic [N_IRQ-1:0]  irqReq,
  input  logic              faultDiv,
  input  logic              faultMem,
  input  logic              faultBus,
  input  logic              modeKernel,
  input  logic              irqEnable,
  output ctrlStrobe_t       strobe,
  output logic              retire
);

  localparam int IDX_W = (N_IRQ > 1) ? $clog2(N_IRQ) : 1;

  instClass_e cls;
  logic       isPriv;
  logic       illegal;
  logic [3:0] syncCause;
  logic       syncHit;
  logic       retReturn;
  logic       irqAny;
  logic [IDX_W-1:0] irqIdx;
  logic       irqTake;

  assign cls     = instClass_e'(instClass);
  assign isPriv  = (cls != IC_PLAIN) && (cls != IC_SYSCALL);
  assign illegal = instValid && isPriv && !modeKernel;

  // synchronous cause, fixed priority
  always_comb begin
    syncCause = CAUSE_NONE;
    if (instValid) begin
      if (illegal)                syncCause = CAUSE_ILLEGAL;
      else if (faultBus)          syncCause = CAUSE_BUSERR;
      else if (faultMem)          syncCause = CAUSE_MEMPROT;
      else if (faultDiv)          syncCause = CAUSE_DIVZERO;
      else if (cls == IC_SYSCALL) syncCause = CAUSE_SYSCALL;
    end
  end

  assign syncHit   = (syncCause != CAUSE_NONE);
  assign retire    = instValid && !syncHit;
  assign retReturn = retire && (cls == IC_RETURN);

  // lowest-numbered pending line wins
  always_comb begin
    irqAny = 1'b0;
    irqIdx = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (irqReq[i]) begin
        irqAny = 1'b1;
        irqIdx = IDX_W'(i);
      end
    end
  end

  assign irqTake = irqEnable && irqAny && !syncHit && !retReturn;

  always_comb begin
    strobe.take     = syncHit || irqTake;
    strobe.cause    = syncHit ? syncCause
                    : (irqTake ? (CAUSE_IRQ_BASE + 4'(irqIdx)) : CAUSE_NONE);
    strobe.saveNext = syncHit ? (syncCause == CAUSE_SYSCALL) : instValid;
    strobe.doReturn = retReturn;
    strobe.setMode  = retire && (cls == IC_SETMODE);
    strobe.irqOn    = retire && (cls == IC_IRQON);
  end

  // R2: user-mode privileged work never retires
  a_r2_user_priv_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && isPriv && !modeKernel) |-> (!retire && strobe.take));

  // R7: with interrupts masked and no instruction, nothing enters
  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!irqEnable && !instValid) |-> !strobe.take);

  // R9: a return and an entry never share a cycle
  a_r9_return_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.take && strobe.doReturn));

endmodule

// File: rtl/priv_dpath.sv
`timescale 1ns/1ps
module priv_dpath
  import privtrap_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter logic [PC_W-1:0] VEC_BASE = 'h100
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrobe_t     strobe,
  input  logic [PC_W-1:0] curPc,
  input  logic            modeWrVal,
  output logic            modeKernel,
  output logic            irqEnable,
  output logic [PC_W-1:0] epcOut,
  output logic [PC_W-1:0] trapVector
);

  localparam logic [PC_W-1:0] PC_STEP = PC_W'(4);

  logic            modeQ;
  logic            prevModeQ;
  logic            ieQ;
  logic [PC_W-1:0] epcQ;
  logic            effMode;

  assign effMode = strobe.setMode ? modeWrVal : modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= 1'b1;
      prevModeQ <= 1'b1;
      ieQ       <= 1'b0;
      epcQ      <= '0;
    end else if (strobe.take) begin
      modeQ     <= 1'b1;
      prevModeQ <= effMode;
      ieQ       <= 1'b0;
      epcQ      <= strobe.saveNext ? (curPc + PC_STEP) : curPc;
    end else if (strobe.doReturn) begin
      modeQ     <= prevModeQ;
      ieQ       <= 1'b1;
    end else begin
      if (strobe.setMode) modeQ <= modeWrVal;
      if (strobe.irqOn)   ieQ   <= 1'b1;
    end
  end

  assign modeKernel = modeQ;
  assign irqEnable  = ieQ;
  assign epcOut     = epcQ;
  assign trapVector = strobe.take
                    ? (VEC_BASE + (PC_W'(strobe.cause) << 2)) : '0;

  // R6: an entry lands in kernel mode with interrupts masked
  a_r6_entry_kernel_masked: assert property (@(posedge clk) disable iff (!rstN)
    strobe.take |=> (modeQ && !ieQ));

  // R9: a return always unmasks
  a_r9_return_unmasks: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doReturn |=> ieQ);

endmodule

// File: rtl/priv_trap_top.sv
`timescale 1ns/1ps
module priv_trap_top
  import privtrap_pkg::*;
#(
  parameter int              PC_W     = 32,
  parameter int              N_IRQ    = 4,   // at most 8 lines
  parameter logic [PC_W-1:0] VEC_BASE = 'h100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instValid,
  input  logic [2:0]       instClass,
  input  logic             modeWrVal,
  input  logic [N_IRQ-1:0] irqReq,
  input  logic             faultDiv,
  input  logic             faultMem,
  input  logic             faultBus,
  input  logic [PC_W-1:0]  curPc,
  output logic             retire,
  output logic             trapTaken,
  output logic [3:0]       trapCause,
  output logic [PC_W-1:0]  trapVector,
  output logic [PC_W-1:0]  epcOut,
  output logic             retTaken,
  output logic             kernelMode
);

  ctrlStrobe_t strobe;
  logic        modeKernel;
  logic        irqEnable;

  priv_ctrl #(.N_IRQ(N_IRQ)) ctrl_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .irqReq(irqReq), .faultDiv(faultDiv), .faultMem(faultMem),
    .faultBus(faultBus), .modeKernel(modeKernel), .irqEnable(irqEnable),
    .strobe(strobe), .retire(retire)
  );

  priv_dpath #(.PC_W(PC_W), .VEC_BASE(VEC_BASE)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curPc(curPc),
    .modeWrVal(modeWrVal), .modeKernel(modeKernel), .irqEnable(irqEnable),
    .epcOut(epcOut), .trapVector(trapVector)
  );

  assign trapTaken  = strobe.take;
  assign trapCause  = strobe.cause;
  assign retTaken   = strobe.doReturn;
  assign kernelMode = modeKernel;

  // R8: the saved address is the PC or its successor
  a_r8_epc_from_pc: assert property (@(posedge clk) disable iff (!rstN)
    trapTaken |=> ((epcOut == $past(curPc)) || (epcOut == $past(curPc) + PC_W'(4))));

  // R5: without a valid instruction no synchronous cause appears
  a_r5_idle_no_sync: assert property (@(posedge clk) disable iff (!rstN)
    (!instValid && trapTaken) |-> (trapCause >= CAUSE_IRQ_BASE));

endmodule

// File: tb/priv_trap_top_tb_top.sv
`timescale 1ns/1ps
module priv_trap_top_tb_top;

  localparam int          PC_W = 32;
  localparam int          NIRQ = 4;
  localparam logic [31:0] BASE = 32'h100;

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic            rstN = 1'b0;
  logic            instValid = 1'b0;
  logic [2:0]      instClass = '0;
  logic            modeWrVal = 1'b0;
  logic [NIRQ-1:0] irqReq = '0;
  logic            faultDiv = 1'b0, faultMem = 1'b0, faultBus = 1'b0;
  logic [PC_W-1:0] curPc = '0;
  logic            retire, trapTaken, retTaken, kernelMode;
  logic [3:0]      trapCause;
  logic [PC_W-1:0] trapVector, epcOut;

  priv_trap_top #(.PC_W(PC_W), .N_IRQ(NIRQ), .VEC_BASE(BASE)) dut_i (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .modeWrVal(modeWrVal), .irqReq(irqReq), .faultDiv(faultDiv),
    .faultMem(faultMem), .faultBus(faultBus), .curPc(curPc),
    .retire(retire), .trapTaken(trapTaken), .trapCause(trapCause),
    .trapVector(trapVector), .epcOut(epcOut), .retTaken(retTaken),
    .kernelMode(kernelMode)
  );

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // bench model of the architectural state
  logic        mK = 1'b1, mIe = 1'b0, mPrev = 1'b1;
  logic [31:0] mEpc = '0;
  int          pcCnt = 1;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic [2:0] cls, input logic wv,
                     input logic [3:0] irq, input logic fd, input logic fm,
                     input logic fb);
    logic [31:0] pc;
    int sc, low, cause;
    logic priv, ill, ret, isRet, irqT, take;
    string tagC;
    @(negedge clk);
    pc = 32'(pcCnt) << 2;
    instValid = v; instClass = cls; modeWrVal = wv; irqReq = irq;
    faultDiv = fd; faultMem = fm; faultBus = fb; curPc = pc;
    #5;
    priv = (cls >= 3'd2);
    ill  = v && priv && !mK;
    sc = 0;
    if (v) begin
      if (ill)            sc = 2;
      else if (fb)        sc = 5;
      else if (fm)        sc = 4;
      else if (fd)        sc = 3;
      else if (cls == 1)  sc = 1;
    end
    ret   = v && (sc == 0);
    isRet = ret && (cls == 3'd2);
    low = -1;
    for (int i = NIRQ - 1; i >= 0; i--) if (irq[i]) low = i;
    irqT  = mIe && (low >= 0) && (sc == 0) && !isRet;
    take  = (sc != 0) || irqT;
    cause = (sc != 0) ? sc : (irqT ? 8 + low : 0);
    tagC  = (sc == 2) ? "R2" : (sc == 1) ? "R4" : (sc != 0) ? "R5" : irqT ? "R7" : "R3";
    chk(ill ? "R2 retire" : "R3 retire", 32'(retire), 32'(ret));
    chk({tagC, " taken"}, 32'(trapTaken), 32'(take));
    chk({tagC, " cause"}, 32'(trapCause), 32'(cause));
    chk("R6 vector", trapVector, take ? BASE + 32'(cause) * 4 : 32'h0);
    chk("R9 retTaken", 32'(retTaken), 32'(isRet));
    chk("R6 kernelMode", 32'(kernelMode), 32'(mK));
    chk("R8 epcOut", epcOut, mEpc);
    @(posedge clk);
    if (take) begin
      mPrev = (ret && cls == 3'd3) ? wv : mK;
      mK = 1'b1; mIe = 1'b0;
      mEpc = (sc == 1 || (sc == 0 && v)) ? pc + 4 : pc;
    end else if (isRet) begin
      mK = mPrev; mIe = 1'b1;
    end else begin
      if (ret && cls == 3'd3) mK = wv;
      if (ret && cls == 3'd7) mIe = 1'b1;
    end
    pcCnt++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #5;
    chk("R1 taken", 32'(trapTaken), 32'h0);
    chk("R1 kernelMode", 32'(kernelMode), 32'h1);
    chk("R1 epcOut", epcOut, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    // R1: masked after reset, so a raised line must not enter
    cyc(1'b0, 3'd0, 1'b0, 4'hF, 1'b0, 1'b0, 1'b0);
    for (int v = 0; v < 2; v++)
      for (int m = 0; m < 2; m++)
        for (int e = 0; e < 2; e++)
          for (int c = 0; c < 8; c++)
            for (int f = 0; f < 8; f++)
              for (int q = 0; q < 16; q++) begin
                if (!mK) cyc(1'b1, 3'd1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
                if (e == 1 && !mIe) cyc(1'b1, 3'd7, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
                if (e == 0 && mIe)  cyc(1'b1, 3'd1, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
                if (m == 0) cyc(1'b1, 3'd3, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
                cyc(v[0], 3'(c), f[1], 4'(q), f[0], f[1], f[2]);
                // follow-up reveals the state left behind (R9 restores)
                if (c == 2 && f == 0) cyc(1'b1, 3'd0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0);
              end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule